// File: doc/BRIEF.md
# Dual-loop synthesizer counter core

This block holds the digital counting and comparison logic of a transmit/receive frequency synthesizer pair. One programmable reference divider turns crystal ticks into a base comparison strobe. A small prescaler derives quarter-rate and twenty-fifth-rate versions of that strobe. A 2-bit region code then chooses which of the three rates each loop compares against, so the transmit and receive loops can run at different comparison frequencies.

Each loop has a programmable feedback divider counting its own VCO ticks, a three-state phase-frequency detector, and a lock monitor. The crystal and both VCO inputs arrive as single-cycle clock-enable ticks sampled on one master clock. Every divider output is therefore a one-cycle strobe in that domain. The detector output is modelled as pump-up, pump-down and drive-enable signals. A deasserted drive-enable stands for the high-impedance state.

Ratios and the region code come from a register bank outside this block. Change them only while reset is held.

Top module: `synth_dual_core`

## Requirements
- R1: The reference divider emits one strobe for every R crystal ticks, for R from 16 to 4095. Clock cycles without a crystal tick do not advance it.
- R2: Any ratio below 16, on the reference divider or on either feedback divider, divides by 16.
- R3: Each feedback divider emits one strobe for every N ticks of its own VCO input, for N from 16 to 16383.
- R4: With region code 2'b00, both loops compare against the undivided reference strobe.
- R5: With region code 2'b01, both loops compare against the reference divided by 4.
- R6: With region code 2'b10, the transmit loop compares against the reference divided by 4 and the receive loop against the reference divided by 25.
- R7: With region code 2'b11, the transmit loop compares against the reference divided by 25 and the receive loop against the reference divided by 4.
- R8: When a loop's comparison strobe arrives and no feedback strobe is pending, pump-up is 1, pump-down is 0 and drive-enable is 1 in the next cycle. This is the positive pulse for a slow or lagging VCO.
- R9: When a feedback strobe arrives and no comparison strobe is pending, pump-down is 1, pump-up is 0 and drive-enable is 1 in the next cycle. This is the negative pulse for a fast or leading VCO.
- R10: When pump-up and pump-down are both 1, both clear in the following cycle. Drive-enable is 1 only while exactly one of them is 1. Coincident strobes therefore produce no drive, with both flags high for a single cycle.
- R11: Each unlock output is 1 from reset. It falls in the cycle after the fourth consecutive comparison strobe that arrives with no over-wide pulse in between.
- R12: In the third consecutive cycle of drive-enable on a loop, that loop's unlock output goes to 1 in the next cycle and its count of good periods restarts. The other loop is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One-cycle crystal tick enable |
| tx_vco_tick | input | 1 | One-cycle transmit VCO tick enable |
| rx_vco_tick | input | 1 | One-cycle receive VCO tick enable |
| ref_ratio | input | 12 | Reference divide ratio |
| tx_ratio | input | 14 | Transmit feedback divide ratio |
| rx_ratio | input | 14 | Receive feedback divide ratio |
| region | input | 2 | Region code selecting the comparison rates |
| tx_ref_strobe | output | 1 | Transmit comparison strobe |
| rx_ref_strobe | output | 1 | Receive comparison strobe |
| tx_fb_strobe | output | 1 | Transmit feedback divider strobe |
| rx_fb_strobe | output | 1 | Receive feedback divider strobe |
| tx_pump_up | output | 1 | Transmit detector up flag |
| tx_pump_dn | output | 1 | Transmit detector down flag |
| tx_pump_en | output | 1 | Transmit detector drive enable (0 means high impedance) |
| rx_pump_up | output | 1 | Receive detector up flag |
| rx_pump_dn | output | 1 | Receive detector down flag |
| rx_pump_en | output | 1 | Receive detector drive enable (0 means high impedance) |
| tx_unlock | output | 1 | Transmit loop unlocked when 1 |
| rx_unlock | output | 1 | Receive loop unlocked when 1 |

## Verification
Divider and prescaler results are judged as the spacing, in cycles, between successive strobes. The fixed latency through the counters therefore drops out, and the first strobe after each reset only starts the measurement. Detector flags are due one cycle after the strobe that sets them, so the bench samples them at the next falling edge.

The lock output falls one cycle after the fourth good comparison strobe. It rises three cycles after drive-enable first appears. Each unlock check is placed on exactly those cycles, with a check on the cycle before that shows the output has not yet moved.

// File: rtl/synth_pkg.sv
package synth_pkg;

    localparam int REF_W_DEF     = 12;
    localparam int FB_W_DEF      = 14;
    localparam int MIN_RATIO     = 16;
    localparam int QUARTER_DIV   = 4;
    localparam int FIFTH_DIV     = 5;
    localparam int FIFTH_STAGES  = 2;
    localparam int LOCK_WIDTH    = 2;
    localparam int LOCK_PERIODS  = 4;

    typedef enum logic [1:0] {
        REGION_PLAIN    = 2'b00,
        REGION_QUARTER  = 2'b01,
        REGION_TXQ_RX25 = 2'b10,
        REGION_TX25_RXQ = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        PRE_1  = 2'd0,
        PRE_4  = 2'd1,
        PRE_25 = 2'd2
    } presc_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    typedef struct packed {
        logic div1;
        logic div4;
        logic div25;
    } cmp_refs_t;

    // Comparison rate used by one loop for a given region code
    function automatic presc_e presc_for(input region_e r, input logic is_rx);
        case (r)
            REGION_PLAIN:    presc_for = PRE_1;
            REGION_QUARTER:  presc_for = PRE_4;
            REGION_TXQ_RX25: presc_for = is_rx ? PRE_25 : PRE_4;
            default:         presc_for = is_rx ? PRE_4 : PRE_25;
        endcase
    endfunction

    function automatic logic pick_ref(input cmp_refs_t c, input presc_e s);
        case (s)
            PRE_1:   pick_ref = c.div1;
            PRE_4:   pick_ref = c.div4;
            default: pick_ref = c.div25;
        endcase
    endfunction

endpackage

// File: rtl/synth_ratio_div.sv
module synth_ratio_div #(
    parameter int W   = 12,
    parameter int MIN = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         strobe
);
    localparam logic [W-1:0] MIN_R = W'(MIN);

    logic [W-1:0] cnt;
    logic [W-1:0] eff;
    logic [W-1:0] last;

    always_comb begin
        eff  = (ratio < MIN_R) ? MIN_R : ratio;
        last = eff - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (tick) begin
                if (cnt >= last) begin
                    cnt    <= '0;
                    strobe <= 1'b1;
                end else begin
                    cnt <= cnt + W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/synth_ref_prescale.sv
module synth_ref_prescale
    import synth_pkg::*;
#(
    parameter int Q  = QUARTER_DIV,
    parameter int F  = FIFTH_DIV,
    parameter int FS = FIFTH_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      base,
    output cmp_refs_t refs
);
    localparam int QW = (Q > 1) ? $clog2(Q) : 1;
    localparam int FW = (F > 1) ? $clog2(F) : 1;

    logic [QW-1:0] qcnt;
    logic          qstb;
    logic [FS:0]   chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt <= '0;
            qstb <= 1'b0;
        end else begin
            qstb <= 1'b0;
            if (base) begin
                if (qcnt == QW'(Q - 1)) begin
                    qcnt <= '0;
                    qstb <= 1'b1;
                end else begin
                    qcnt <= qcnt + QW'(1);
                end
            end
        end
    end

    assign chain[0] = base;

    // Cascade of divide-by-F stages forming the slowest comparison rate
    for (genvar g = 0; g < FS; g++) begin : g_fifth
        logic [FW-1:0] c;
        logic          stb_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                c     <= '0;
                stb_q <= 1'b0;
            end else begin
                stb_q <= 1'b0;
                if (chain[g]) begin
                    if (c == FW'(F - 1)) begin
                        c     <= '0;
                        stb_q <= 1'b1;
                    end else begin
                        c <= c + FW'(1);
                    end
                end
            end
        end
        assign chain[g+1] = stb_q;
    end

    always_comb begin
        refs.div1  = base;
        refs.div4  = qstb;
        refs.div25 = chain[FS];
    end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
    import synth_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_s,
    input  logic  fb_s,
    output pump_t pump,
    output logic  drive
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pump <= '0;
        end else if (pump.up && pump.dn) begin
            // Mutual clear; a strobe landing on the clear cycle is kept
            pump.up <= ref_s;
            pump.dn <= fb_s;
        end else begin
            pump.up <= pump.up | ref_s;
            pump.dn <= pump.dn | fb_s;
        end
    end

    assign drive = pump.up ^ pump.dn;
endmodule

// File: rtl/synth_lock_mon.sv
module synth_lock_mon #(
    parameter int WID = 2,
    parameter int PER = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic drive,
    input  logic period_s,
    output logic unlock
);
    localparam int WW = $clog2(WID + 2);
    localparam int GW = $clog2(PER + 1);

    logic [WW-1:0] w;
    logic [GW-1:0] good;
    logic          bad;

    assign bad = drive && (w >= WW'(WID));

    always_ff @(posedge clk) begin
        if (rst) begin
            w      <= '0;
            good   <= '0;
            unlock <= 1'b1;
        end else begin
            if (!drive)
                w <= '0;
            else if (w < WW'(WID))
                w <= w + WW'(1);

            if (bad) begin
                good   <= '0;
                unlock <= 1'b1;
            end else if (period_s && (good < GW'(PER))) begin
                good <= good + GW'(1);
                if (good == GW'(PER - 1))
                    unlock <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/synth_dual_core.sv
module synth_dual_core
    import synth_pkg::*;
#(
    parameter int REF_W   = REF_W_DEF,
    parameter int FB_W    = FB_W_DEF,
    parameter int MIN_R   = MIN_RATIO,
    parameter int LK_WID  = LOCK_WIDTH,
    parameter int LK_PER  = LOCK_PERIODS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_tick,
    input  logic             tx_vco_tick,
    input  logic             rx_vco_tick,
    input  logic [REF_W-1:0] ref_ratio,
    input  logic [FB_W-1:0]  tx_ratio,
    input  logic [FB_W-1:0]  rx_ratio,
    input  logic [1:0]       region,
    output logic             tx_ref_strobe,
    output logic             rx_ref_strobe,
    output logic             tx_fb_strobe,
    output logic             rx_fb_strobe,
    output logic             tx_pump_up,
    output logic             tx_pump_dn,
    output logic             tx_pump_en,
    output logic             rx_pump_up,
    output logic             rx_pump_dn,
    output logic             rx_pump_en,
    output logic             tx_unlock,
    output logic             rx_unlock
);
    localparam int LOOPS = 2;

    logic            ref_base;
    cmp_refs_t       refs;
    logic [LOOPS-1:0] vco_tick;
    logic [FB_W-1:0] fb_ratio [LOOPS];
    logic [LOOPS-1:0] cmp_s, fb_s, up_v, dn_v, en_v, unl_v;

    synth_ratio_div #(.W(REF_W), .MIN(MIN_R)) u_ref_div (
        .clk    (clk),
        .rst    (rst),
        .tick   (xtal_tick),
        .ratio  (ref_ratio),
        .strobe (ref_base)
    );

    synth_ref_prescale u_prescale (
        .clk  (clk),
        .rst  (rst),
        .base (ref_base),
        .refs (refs)
    );

    assign vco_tick    = {rx_vco_tick, tx_vco_tick};
    assign fb_ratio[0] = tx_ratio;
    assign fb_ratio[1] = rx_ratio;

    // Loop 0 is transmit, loop 1 is receive
    for (genvar i = 0; i < LOOPS; i++) begin : g_loop
        pump_t p;

        assign cmp_s[i] = pick_ref(refs, presc_for(region_e'(region), 1'(i)));

        synth_ratio_div #(.W(FB_W), .MIN(MIN_R)) u_fb_div (
            .clk    (clk),
            .rst    (rst),
            .tick   (vco_tick[i]),
            .ratio  (fb_ratio[i]),
            .strobe (fb_s[i])
        );

        synth_pfd u_pfd (
            .clk   (clk),
            .rst   (rst),
            .ref_s (cmp_s[i]),
            .fb_s  (fb_s[i]),
            .pump  (p),
            .drive (en_v[i])
        );

        assign up_v[i] = p.up;
        assign dn_v[i] = p.dn;

        synth_lock_mon #(.WID(LK_WID), .PER(LK_PER)) u_lock (
            .clk      (clk),
            .rst      (rst),
            .drive    (en_v[i]),
            .period_s (cmp_s[i]),
            .unlock   (unl_v[i])
        );
    end

    assign tx_ref_strobe = cmp_s[0];
    assign rx_ref_strobe = cmp_s[1];
    assign tx_fb_strobe  = fb_s[0];
    assign rx_fb_strobe  = fb_s[1];
    assign tx_pump_up    = up_v[0];
    assign tx_pump_dn    = dn_v[0];
    assign tx_pump_en    = en_v[0];
    assign rx_pump_up    = up_v[1];
    assign rx_pump_dn    = dn_v[1];
    assign rx_pump_en    = en_v[1];
    assign tx_unlock     = unl_v[0];
    assign rx_unlock     = unl_v[1];
endmodule

// File: rtl/synth_dual_core_chk.sv
module synth_dual_core_chk #(
    parameter int MIN_R  = 16,
    parameter int LK_WID = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] region,
    input logic       tx_vco_tick,
    input logic       rx_vco_tick,
    input logic       tx_ref_strobe,
    input logic       rx_ref_strobe,
    input logic       tx_fb_strobe,
    input logic       rx_fb_strobe,
    input logic       tx_pump_up,
    input logic       tx_pump_dn,
    input logic       tx_pump_en,
    input logic       rx_pump_up,
    input logic       rx_pump_dn,
    input logic       rx_pump_en,
    input logic       tx_unlock,
    input logic       rx_unlock
);
    logic [7:0]  run_tx, run_rx;
    logic [15:0] gap_tx, gap_rx;
    logic        armed_tx, armed_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_tx   <= '0;
            run_rx   <= '0;
            gap_tx   <= '0;
            gap_rx   <= '0;
            armed_tx <= 1'b0;
            armed_rx <= 1'b0;
        end else begin
            run_tx <= !tx_pump_en ? 8'd0 : ((run_tx == 8'hFF) ? run_tx : run_tx + 8'd1);
            run_rx <= !rx_pump_en ? 8'd0 : ((run_rx == 8'hFF) ? run_rx : run_rx + 8'd1);
            if (tx_fb_strobe) begin
                gap_tx   <= {15'd0, tx_vco_tick};
                armed_tx <= 1'b1;
            end else if (tx_vco_tick && gap_tx != 16'hFFFF) begin
                gap_tx <= gap_tx + 16'd1;
            end
            if (rx_fb_strobe) begin
                gap_rx   <= {15'd0, rx_vco_tick};
                armed_rx <= 1'b1;
            end else if (rx_vco_tick && gap_rx != 16'hFFFF) begin
                gap_rx <= gap_rx + 16'd1;
            end
        end
    end

    assert_gap_tx_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_fb_strobe && armed_tx) |-> (gap_tx >= 16'(MIN_R)));
    assert_gap_rx_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_fb_strobe && armed_rx) |-> (gap_rx >= 16'(MIN_R)));

    assert_same_ref_R4: assert property (@(posedge clk) disable iff (rst)
        (region == 2'b00) |-> (tx_ref_strobe == rx_ref_strobe));
    assert_same_ref_R5: assert property (@(posedge clk) disable iff (rst)
        (region == 2'b01) |-> (tx_ref_strobe == rx_ref_strobe));

    assert_up_src_tx_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pump_up) |-> $past(tx_ref_strobe));
    assert_up_src_rx_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_pump_up) |-> $past(rx_ref_strobe));
    assert_dn_src_tx_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pump_dn) |-> $past(tx_fb_strobe));
    assert_dn_src_rx_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_pump_dn) |-> $past(rx_fb_strobe));

    assert_lock_edge_tx_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_unlock) |-> $past(tx_ref_strobe));
    assert_lock_edge_rx_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_unlock) |-> $past(rx_ref_strobe));

    assert_wide_tx_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_pump_en && run_tx >= 8'(LK_WID)) |=> tx_unlock);
    assert_wide_rx_R12: assert property (@(posedge clk) disable iff (rst)
        (rx_pump_en && run_rx >= 8'(LK_WID)) |=> rx_unlock);
endmodule

bind synth_dual_core synth_dual_core_chk #(.MIN_R(MIN_R), .LK_WID(LK_WID)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .region        (region),
    .tx_vco_tick   (tx_vco_tick),
    .rx_vco_tick   (rx_vco_tick),
    .tx_ref_strobe (tx_ref_strobe),
    .rx_ref_strobe (rx_ref_strobe),
    .tx_fb_strobe  (tx_fb_strobe),
    .rx_fb_strobe  (rx_fb_strobe),
    .tx_pump_up    (tx_pump_up),
    .tx_pump_dn    (tx_pump_dn),
    .tx_pump_en    (tx_pump_en),
    .rx_pump_up    (rx_pump_up),
    .rx_pump_dn    (rx_pump_dn),
    .rx_pump_en    (rx_pump_en),
    .tx_unlock     (tx_unlock),
    .rx_unlock     (rx_unlock)
);

// File: tb/sim_synth_dual_core.sv
module sim_synth_dual_core;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        xtal_tick = 1'b0, tx_vco_tick = 1'b0, rx_vco_tick = 1'b0;
    logic [11:0] ref_ratio = 12'd16;
    logic [13:0] tx_ratio = 14'd16, rx_ratio = 14'd16;
    logic [1:0]  region = 2'b00;
    logic tx_ref_strobe, rx_ref_strobe, tx_fb_strobe, rx_fb_strobe;
    logic tx_pump_up, tx_pump_dn, tx_pump_en, rx_pump_up, rx_pump_dn, rx_pump_en;
    logic tx_unlock, rx_unlock;

    synth_dual_core u0 (.*);

    int xt_mode = 1;
    bit tx_on = 1'b1, rx_on = 1'b1;
    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    int    exp_q [4][$];
    string tag_q [4][$];
    int    last_c [4];
    bit    armed [4];

    always @(posedge clk) begin
        cyc++;
        #1;
        case (xt_mode)
            0:       xtal_tick = 1'b0;
            1:       xtal_tick = 1'b1;
            default: xtal_tick = ~xtal_tick;
        endcase
        tx_vco_tick = tx_on;
        rx_vco_tick = rx_on;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: channel 0 tx_ref, 1 rx_ref, 2 tx_fb, 3 rx_fb
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] s;
            s = {rx_fb_strobe, tx_fb_strobe, rx_ref_strobe, tx_ref_strobe};
            for (int i = 0; i < 4; i++) begin
                if (s[i]) begin
                    if (armed[i] && exp_q[i].size() > 0) begin
                        int    e;
                        string t;
                        e = exp_q[i].pop_front();
                        t = tag_q[i].pop_front();
                        check((cyc - last_c[i]) == e, t, cyc - last_c[i], e);
                    end
                    last_c[i] = cyc;
                    armed[i]  = 1'b1;
                end
            end
        end
    end

    task automatic expect_gap(input int ch, input int gap, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q[ch].push_back(gap);
            tag_q[ch].push_back(tag);
        end
    endtask

    task automatic start(input int rr, input int tr, input int xr, input logic [1:0] rg,
                         input int xm, input bit ton, input bit xon);
        @(posedge clk);
        #2;
        rst = 1'b1;
        ref_ratio = 12'(rr);
        tx_ratio  = 14'(tr);
        rx_ratio  = 14'(xr);
        region    = rg;
        xt_mode   = xm;
        tx_on     = ton;
        rx_on     = xon;
        for (int i = 0; i < 4; i++) begin
            exp_q[i].delete();
            tag_q[i].delete();
            armed[i] = 1'b0;
        end
    endtask

    task automatic release_rst();
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
    endtask

    task automatic drain();
        while (exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size() > 0)
            @(posedge clk);
    endtask

    task automatic wait_neg(input int which);
        do @(negedge clk);
        while (!((which == 0 && tx_ref_strobe) || (which == 2 && tx_fb_strobe)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        repeat (130000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int en_seen;
        // Reset state (R11: unlock set from reset)
        start(16, 16, 16, 2'b00, 1, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        check(tx_pump_up == 0 && tx_pump_dn == 0 && tx_pump_en == 0, "R10 reset pumps", tx_pump_en, 0);
        check(tx_unlock == 1 && rx_unlock == 1, "R11 reset unlock", tx_unlock & rx_unlock, 1);
        check(tx_ref_strobe == 0 && tx_fb_strobe == 0, "R1 reset strobes", tx_ref_strobe, 0);

        // R1 R3 R4: plain region
        start(16, 16, 20, 2'b00, 1, 1'b1, 1'b1);
        expect_gap(0, 16, 3, "R4 tx ref");
        expect_gap(1, 16, 3, "R1 rx ref");
        expect_gap(2, 16, 3, "R3 tx fb");
        expect_gap(3, 20, 3, "R3 rx fb");
        release_rst();
        drain();

        // R5: quarter rate on both loops
        start(20, 16, 16, 2'b01, 1, 1'b1, 1'b1);
        expect_gap(0, 80, 2, "R5 tx ref");
        expect_gap(1, 80, 2, "R5 rx ref");
        release_rst();
        drain();

        // R6: tx quarter, rx twenty-fifth
        start(16, 16, 16, 2'b10, 1, 1'b1, 1'b1);
        expect_gap(0, 64, 2, "R6 tx ref");
        expect_gap(1, 400, 2, "R6 rx ref");
        release_rst();
        drain();

        // R7: tx twenty-fifth, rx quarter
        start(16, 16, 16, 2'b11, 1, 1'b1, 1'b1);
        expect_gap(0, 400, 2, "R7 tx ref");
        expect_gap(1, 64, 2, "R7 rx ref");
        release_rst();
        drain();

        // R2: ratios below the minimum
        start(5, 0, 15, 2'b00, 1, 1'b1, 1'b1);
        expect_gap(0, 16, 2, "R2 ref clamp");
        expect_gap(2, 16, 2, "R2 tx clamp");
        expect_gap(3, 16, 2, "R2 rx clamp");
        release_rst();
        drain();

        // R1: crystal ticks on alternate cycles only
        start(16, 16, 16, 2'b00, 2, 1'b1, 1'b1);
        expect_gap(0, 32, 2, "R1 tick gating");
        release_rst();
        drain();

        // R1 R3: largest ratios
        start(4095, 16383, 16, 2'b00, 1, 1'b1, 1'b1);
        expect_gap(0, 4095, 2, "R1 max ref");
        expect_gap(2, 16383, 1, "R3 max fb");
        release_rst();
        drain();

        // R10 R11: matched loops lock
        start(16, 16, 16, 2'b00, 1, 1'b1, 1'b1);
        release_rst();
        wait_neg(0);
        @(negedge clk);
        check(tx_pump_up && tx_pump_dn && !tx_pump_en, "R10 coincident both set", {tx_pump_up, tx_pump_dn, tx_pump_en}, 6);
        @(negedge clk);
        check(!tx_pump_up && !tx_pump_dn, "R10 coincident cleared", {tx_pump_up, tx_pump_dn}, 0);
        wait_neg(0);
        wait_neg(0);
        @(negedge clk);
        check(tx_unlock == 1, "R11 three periods", tx_unlock, 1);
        wait_neg(0);
        @(negedge clk);
        check(tx_unlock == 0, "R11 locked after four", tx_unlock, 0);
        check(rx_unlock == 0, "R11 rx locked", rx_unlock, 0);
        en_seen = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tx_pump_en) en_seen++;
        end
        check(en_seen == 0, "R10 no drive when matched", en_seen, 0);

        // R8 R12: stop the tx VCO while locked
        tx_on = 1'b0;
        wait_neg(0);
        @(negedge clk);
        check(tx_pump_up && !tx_pump_dn && tx_pump_en, "R8 up pulse", {tx_pump_up, tx_pump_dn, tx_pump_en}, 5);
        @(negedge clk);
        @(negedge clk);
        check(tx_unlock == 0, "R12 not before third cycle", tx_unlock, 0);
        @(negedge clk);
        check(tx_unlock == 1, "R12 wide pulse unlocks", tx_unlock, 1);
        check(rx_unlock == 0, "R12 rx unaffected", rx_unlock, 0);

        // R9: no crystal ticks, VCO running
        start(16, 16, 16, 2'b00, 0, 1'b1, 1'b1);
        release_rst();
        wait_neg(2);
        @(negedge clk);
        check(!tx_pump_up && tx_pump_dn && tx_pump_en, "R9 down pulse", {tx_pump_up, tx_pump_dn, tx_pump_en}, 3);
        check(tx_unlock == 1, "R11 stays unlocked", tx_unlock, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule